// File: doc/BRIEF.md
# Fetch Address Sequencer with Single-Entry Return Stack

This block keeps the instruction fetch address for a small controller core. After each executed instruction it moves the address forward by that instruction's length in bytes. A taken branch loads an absolute target instead. A subroutine call saves the address of the following instruction in a one-entry return register and then branches. A return loads the saved address back.

A one-bit depth flag records whether a call is outstanding. If a call arrives while a call is already outstanding, or a return arrives while none is, the block raises a one-cycle restart pulse. In that same cycle the fetch address is 0x000 and the depth flag is clear. The low byte of the return register doubles as a general data byte that the core can read and write. A data write sets the two upper bits to zero and marks them as not trustworthy. Branch conditions and instruction decoding are resolved upstream, so the block receives only strobes.

Top module: `fetch_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `pc`=0x000, `depth`=0, `restart`=0 and `hi_valid`=0.
- R2: With only `step` asserted, `pc` becomes (`pc` + `ilen`) modulo 1024 one cycle later. `ilen`=0, or no strobe at all, leaves `pc` unchanged.
- R3: `br_take` loads `dest` into `pc` one cycle later and overrides `step`.
- R4: `call_en` at `depth`=0 saves `pc`+`ilen` in the return register and loads `dest` into `pc`. In the same cycle it sets `depth` to 1 and `hi_valid` to 1. The low 8 bits of the saved word appear on `dreg_rdata`.
- R5: `ret_en` at `depth`=1 loads the 10-bit return register into `pc` and clears `depth`. The register keeps its value, so `dreg_rdata` is unchanged afterwards.
- R6: `call_en` at `depth`=1 produces `restart`=1 for one cycle, with `pc`=0x000 and `depth`=0 in that cycle. The return register is not written.
- R7: `ret_en` at `depth`=0 produces `restart`=1 for one cycle, with `pc`=0x000 and `depth`=0.
- R8: `dreg_we` writes `dreg_wdata` into bits 7:0 of the return register and zero into bits 9:8, and clears `hi_valid`. A later return goes to {2'b00, data}.
- R9: The strobes take effect in this order of priority: call, then return, then branch, then step. A call also wins over `dreg_we` for the return register.
- R10: Reset does not clear the return register. `dreg_rdata` after a reset equals its value before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| step | input | 1 | Instruction completed, advance sequentially |
| ilen | input | 2 | Byte length of the current instruction |
| br_take | input | 1 | Taken branch strobe |
| call_en | input | 1 | Subroutine call strobe |
| ret_en | input | 1 | Subroutine return strobe |
| dest | input | 10 | Branch or call target address |
| dreg_we | input | 1 | Data byte write strobe |
| dreg_wdata | input | 8 | Data byte to write |
| pc | output | 10 | Current fetch address |
| depth | output | 1 | Call outstanding flag |
| restart | output | 1 | One-cycle restart pulse on stack misuse |
| hi_valid | output | 1 | Upper two bits of the return register hold a real address |
| dreg_rdata | output | 8 | Low byte of the return register |

## Verification
Every result is due exactly one clock edge after the strobe that causes it, because `pc`, `depth`, `restart`, `hi_valid` and the return register are all registered and `dreg_rdata` comes straight from that register. The bench changes inputs just after a falling edge, lets one rising edge pass, and compares at the next falling edge. For the restart pulse it also checks the following cycle, to confirm the pulse has dropped. For the reset-retention case it compares the data byte before and after a reset pulse.

// File: rtl/fetch_seq_pkg.sv
// Shared types for the fetch sequencer.
// Assumes: the operation code is decided once per cycle by the control unit.
package fetch_seq_pkg;
    typedef enum logic [2:0] {
        SEQ_HOLD,
        SEQ_STEP,
        SEQ_JUMP,
        SEQ_CALL,
        SEQ_RET,
        SEQ_FAULT
    } seq_op_e;
endpackage

// File: rtl/fetch_seq_ctrl.sv
// Control unit: turns the strobes into one operation by fixed priority,
// keeps the one-bit call depth and emits the restart pulse.
// Assumes: strobes are valid for exactly the cycle they are high.
module fetch_seq_ctrl
    import fetch_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    step,
    input  logic    br_take,
    input  logic    call_en,
    input  logic    ret_en,
    output seq_op_e op,
    output logic    depth,
    output logic    restart
);
    // Select the operation: misuse first, then call, return, branch, step.
    always_comb begin
        if ((call_en && depth) || (ret_en && !call_en && !depth))
            op = SEQ_FAULT;
        else if (call_en)
            op = SEQ_CALL;
        else if (ret_en)
            op = SEQ_RET;
        else if (br_take)
            op = SEQ_JUMP;
        else if (step)
            op = SEQ_STEP;
        else
            op = SEQ_HOLD;
    end

    // Track call depth and register the restart pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            depth   <= 1'b0;
            restart <= 1'b0;
        end else begin
            restart <= (op == SEQ_FAULT);
            case (op)
                SEQ_CALL:  depth <= 1'b1;
                SEQ_RET:   depth <= 1'b0;
                SEQ_FAULT: depth <= 1'b0;
                default:   depth <= depth;
            endcase
        end
    end
endmodule

// File: rtl/fetch_seq_pc.sv
// Fetch address register with its length adder.
// Assumes: arithmetic wraps modulo 2**ADDR_W.
module fetch_seq_pc
    import fetch_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_op_e           op,
    input  logic [LEN_W-1:0]  ilen,
    input  logic [ADDR_W-1:0] dest,
    input  logic [ADDR_W-1:0] saved,
    output logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] next_seq
);
    // Address of the instruction that follows the current one.
    always_comb next_seq = pc + ADDR_W'(ilen);

    // Load the fetch address according to the selected operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            case (op)
                SEQ_STEP:            pc <= next_seq;
                SEQ_JUMP, SEQ_CALL:  pc <= dest;
                SEQ_RET:             pc <= saved;
                SEQ_FAULT:           pc <= '0;
                default:             pc <= pc;
            endcase
        end
    end
endmodule

// File: rtl/fetch_seq_stack.sv
// Single-entry return register whose low byte is also a data byte.
// Assumes: the contents survive reset; only the validity flag is reset.
module fetch_seq_stack
    import fetch_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_op_e           op,
    input  logic [ADDR_W-1:0] ret_addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [ADDR_W-1:0] word,
    output logic              hi_valid
);
    localparam int HI_W = ADDR_W - DATA_W;

    // Store the return address on a call, or the data byte on a write.
    always_ff @(posedge clk) begin
        if (op == SEQ_CALL)
            word <= ret_addr;
        else if (wr_en)
            word <= {{HI_W{1'b0}}, wr_data};
    end

    // Track whether the upper bits came from a call.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_valid <= 1'b0;
        else if (op == SEQ_CALL)
            hi_valid <= 1'b1;
        else if (wr_en)
            hi_valid <= 1'b0;
    end
endmodule

// File: rtl/fetch_seq.sv
// Top of the fetch sequencer: control, address register and return register.
// Assumes: branch conditions and decoding are resolved upstream.
module fetch_seq
    import fetch_seq_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic [LEN_W-1:0]  ilen,
    input  logic              br_take,
    input  logic              call_en,
    input  logic              ret_en,
    input  logic [ADDR_W-1:0] dest,
    input  logic              dreg_we,
    input  logic [DATA_W-1:0] dreg_wdata,
    output logic [ADDR_W-1:0] pc,
    output logic              depth,
    output logic              restart,
    output logic              hi_valid,
    output logic [DATA_W-1:0] dreg_rdata
);
    seq_op_e           op;
    logic [ADDR_W-1:0] ret_word;
    logic [ADDR_W-1:0] next_seq;

    fetch_seq_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .step(step), .br_take(br_take),
        .call_en(call_en), .ret_en(ret_en), .op(op),
        .depth(depth), .restart(restart)
    );

    fetch_seq_pc #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_pc (
        .clk(clk), .rst_n(rst_n), .op(op), .ilen(ilen), .dest(dest),
        .saved(ret_word), .pc(pc), .next_seq(next_seq)
    );

    fetch_seq_stack #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_stack (
        .clk(clk), .rst_n(rst_n), .op(op), .ret_addr(next_seq),
        .wr_en(dreg_we), .wr_data(dreg_wdata),
        .word(ret_word), .hi_valid(hi_valid)
    );

    // Low byte of the return register is the readable data byte.
    always_comb dreg_rdata = ret_word[DATA_W-1:0];
endmodule

// File: rtl/fetch_seq_chk.sv
// Property checker for fetch_seq, attached by bind.
// Assumes: the bench holds rst_n low from time zero.
module fetch_seq_chk #(
    parameter int ADDR_W = 10,
    parameter int LEN_W  = 2,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step,
    input logic [LEN_W-1:0]  ilen,
    input logic              br_take,
    input logic              call_en,
    input logic              ret_en,
    input logic [ADDR_W-1:0] dest,
    input logic              dreg_we,
    input logic [DATA_W-1:0] dreg_wdata,
    input logic [ADDR_W-1:0] pc,
    input logic              depth,
    input logic              restart,
    input logic              hi_valid,
    input logic [ADDR_W-1:0] ret_word
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (pc == '0 && !depth && !restart && !hi_valid));

    // R2
    seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !br_take && !call_en && !ret_en)
        |=> pc == ADDR_W'($past(pc) + ADDR_W'($past(ilen))));

    // R3
    branch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_take && !call_en && !ret_en) |=> pc == $past(dest));

    // R4
    call_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_en && !depth) |=> (pc == $past(dest) && depth && hi_valid));

    // R5
    return_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !call_en && depth) |=> (pc == $past(ret_word) && !depth));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_en && depth) |=> (restart && pc == '0 && !depth && $stable(ret_word)));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_en && !call_en && !depth) |=> (restart && pc == '0 && !depth));

    // R8
    data_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dreg_we && !call_en)
        |=> (ret_word == ADDR_W'($past(dreg_wdata)) && !hi_valid));
endmodule

bind fetch_seq fetch_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .step(step), .ilen(ilen), .br_take(br_take),
    .call_en(call_en), .ret_en(ret_en), .dest(dest), .dreg_we(dreg_we),
    .dreg_wdata(dreg_wdata), .pc(pc), .depth(depth), .restart(restart),
    .hi_valid(hi_valid), .ret_word(ret_word)
);

// File: tb/fetch_seq_test.sv
module fetch_seq_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step = 1'b0;
    logic [1:0] ilen = '0;
    logic       br_take = 1'b0;
    logic       call_en = 1'b0;
    logic       ret_en = 1'b0;
    logic [9:0] dest = '0;
    logic       dreg_we = 1'b0;
    logic [7:0] dreg_wdata = '0;
    logic [9:0] pc;
    logic       depth;
    logic       restart;
    logic       hi_valid;
    logic [7:0] dreg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    fetch_seq uut (
        .clk(clk), .rst_n(rst_n), .step(step), .ilen(ilen), .br_take(br_take),
        .call_en(call_en), .ret_en(ret_en), .dest(dest), .dreg_we(dreg_we),
        .dreg_wdata(dreg_wdata), .pc(pc), .depth(depth), .restart(restart),
        .hi_valid(hi_valid), .dreg_rdata(dreg_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Apply strobes after a falling edge, let one rising edge pass, then clear.
    task automatic cyc(input bit s, input int len, input bit b, input bit c,
                       input bit r, input int d, input bit w, input int wd);
        step = s; ilen = 2'(len); br_take = b; call_en = c; ret_en = r;
        dest = 10'(d); dreg_we = w; dreg_wdata = 8'(wd);
        @(negedge clk);
        step = 0; ilen = 0; br_take = 0; call_en = 0; ret_en = 0; dreg_we = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        @(negedge clk); @(negedge clk);
        chk("R1 pc", pc, 0); chk("R1 depth", depth, 0);
        chk("R1 restart", restart, 0); chk("R1 hi_valid", hi_valid, 0);
        rst_n = 1;
    endtask

    task automatic t_step();
        cyc(1, 1, 0, 0, 0, 0, 0, 0); chk("R2 len1", pc, 1);
        cyc(1, 3, 0, 0, 0, 0, 0, 0); chk("R2 len3", pc, 4);
        cyc(1, 2, 0, 0, 0, 0, 0, 0); chk("R2 len2", pc, 6);
        cyc(1, 0, 0, 0, 0, 0, 0, 0); chk("R2 len0", pc, 6);
        cyc(0, 3, 0, 0, 0, 0, 0, 0); chk("R2 idle", pc, 6);
        cyc(0, 0, 1, 0, 0, 1023, 0, 0); chk("R3 jump top", pc, 1023);
        cyc(1, 2, 0, 0, 0, 0, 0, 0); chk("R2 wrap", pc, 1);
    endtask

    task automatic t_jump();
        cyc(1, 3, 1, 0, 0, 'h155, 0, 0); chk("R3 over step", pc, 'h155);
    endtask

    task automatic t_call_ret();
        cyc(0, 2, 0, 1, 0, 'h200, 0, 0);
        chk("R4 pc", pc, 'h200); chk("R4 depth", depth, 1);
        chk("R4 hi_valid", hi_valid, 1); chk("R4 saved low", dreg_rdata, 'h57);
        cyc(1, 1, 0, 0, 0, 0, 0, 0); chk("R2 in sub", pc, 'h201);
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R5 pc", pc, 'h157); chk("R5 depth", depth, 0);
        chk("R5 kept", dreg_rdata, 'h57);
    endtask

    task automatic t_overflow();
        cyc(0, 1, 0, 1, 0, 'h300, 0, 0); chk("R4 second call", pc, 'h300);
        cyc(0, 1, 0, 1, 0, 'h010, 0, 0);
        chk("R6 restart", restart, 1); chk("R6 pc", pc, 0);
        chk("R6 depth", depth, 0); chk("R6 stack kept", dreg_rdata, 'h58);
        @(negedge clk); chk("R6 pulse width", restart, 0);
    endtask

    task automatic t_underflow();
        cyc(1, 3, 0, 0, 0, 0, 0, 0); chk("R2 pre", pc, 3);
        cyc(0, 0, 0, 0, 1, 0, 0, 0);
        chk("R7 restart", restart, 1); chk("R7 pc", pc, 0); chk("R7 depth", depth, 0);
        @(negedge clk); chk("R7 pulse width", restart, 0);
    endtask

    task automatic t_data();
        cyc(0, 1, 0, 1, 0, 'h080, 0, 0); chk("R4 call", pc, 'h080);
        cyc(0, 0, 0, 0, 0, 0, 1, 'hC3);
        chk("R8 rdata", dreg_rdata, 'hC3); chk("R8 hi_valid", hi_valid, 0);
        cyc(0, 0, 0, 0, 1, 0, 0, 0); chk("R8 return to data", pc, 'h0C3);
    endtask

    task automatic t_priority();
        cyc(1, 1, 1, 1, 1, 'h3FF, 1, 'h11);
        chk("R9 call wins pc", pc, 'h3FF); chk("R9 depth", depth, 1);
        chk("R9 call over write", dreg_rdata, 'hC4); chk("R9 hi_valid", hi_valid, 1);
        cyc(1, 1, 1, 0, 1, 'h002, 0, 0); chk("R9 ret over branch", pc, 'h0C4);
        cyc(1, 1, 1, 0, 0, 'h099, 0, 0); chk("R9 branch over step", pc, 'h099);
    endtask

    task automatic t_keep();
        cyc(0, 0, 0, 0, 0, 0, 1, 'h6E); chk("R8 write", dreg_rdata, 'h6E);
        rst_n = 0; @(negedge clk); rst_n = 1;
        chk("R10 pc", pc, 0); chk("R10 kept", dreg_rdata, 'h6E);
        chk("R10 hi_valid", hi_valid, 0);
    endtask

    initial begin
        t_reset();
        t_step();
        t_jump();
        t_call_ret();
        t_overflow();
        t_underflow();
        t_data();
        t_priority();
        t_keep();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog: actual=hung expected=finished");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule